// File: doc/BRIEF.md
# Multi-Source Trigger Event Detector

This block watches a set of candidate trigger sources for a sampling front end and issues a single-clock trigger pulse when the one currently selected produces its event. The candidates are a software strobe, an external digital pin, eight backplane trigger lines (one chosen by index), a star trigger line, a synchronization-bus trigger, and a level trigger on any one of four 16-bit sample channels. The asynchronous digital inputs pass through a two-flop synchronizer clocked by the timebase, and an edge of the configured direction is then picked out.

The level trigger uses straight-binary samples. An 8-bit level code, in which 0x80 stands for mid-scale, is held against the top byte of the selected channel. A pulse is produced when consecutive valid samples cross that level in the configured direction. All configuration is static input. The detector produces nothing while it is disarmed.

Top module: `trig_event_detect`

## Requirements
- R1: While reset is held, and on the first clock after it is released, `trigOut` is 0. The first valid sample after reset only records history and never triggers.
- R2: With `srcSel`=0 (software), a 0-to-1 change of `swStrobe` seen at a clock edge sets `trigOut` at that same edge. Holding `swStrobe` high gives only one pulse.
- R3: With `srcSel`=1 (external pin), an `extPin` transition gives one pulse. The transition is rising when `edgeFall`=0 and falling when `edgeFall`=1, and the opposite transition gives none. `trigOut` rises at the third clock edge, counting the first edge that samples the new level.
- R4: With `srcSel`=2 (backplane), only line `bpLines[bpSel]` is watched, with the same polarity and latency rules as R3. Edges on the other lines give no pulse.
- R5: With `srcSel`=3 (star), `starPin` follows the polarity and latency rules of R3.
- R6: With `srcSel`=4 (sync bus), a rising edge of `syncPin` triggers whatever the value of `edgeFall`, and a falling edge never triggers. Latency is as in R3.
- R7: With `srcSel`=5 (level), only channel `anaChan` is compared, taken from `sampleData[16*anaChan+15 : 16*anaChan]`. Only cycles with `sampleValid`=1 count as samples, and `trigOut` rises at the clock edge that accepts the crossing sample.
- R8: With `slopeNeg`=0, a trigger happens when the previous valid sample's top byte is below `levelCode` and the current sample's top byte is at or above it.
- R9: With `slopeNeg`=1, a trigger happens when the previous valid sample's top byte is at or above `levelCode` and the current sample's top byte is below it.
- R10: `trigOut` is never high for two clocks in a row. It stays 0 for any event seen while `armEn`=0.
- R11: An event on a source that is not selected gives no pulse. The codes `srcSel`=6 and 7 select no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rstN | input | 1 | Asynchronous reset, active low |
| armEn | input | 1 | Detector armed when 1 |
| srcSel | input | 3 | Source code: 0 soft, 1 ext, 2 backplane, 3 star, 4 sync, 5 level, 6-7 none |
| edgeFall | input | 1 | Digital polarity: 0 rising, 1 falling |
| bpSel | input | 3 | Backplane line index |
| slopeNeg | input | 1 | Level slope: 0 upward crossing, 1 downward crossing |
| anaChan | input | 2 | Sample channel for level trigger |
| levelCode | input | 8 | Trigger level, offset binary (0x80 = mid-scale) |
| swStrobe | input | 1 | Software trigger request, synchronous |
| extPin | input | 1 | External trigger pin, asynchronous |
| bpLines | input | 8 | Backplane trigger lines, asynchronous |
| starPin | input | 1 | Star trigger line, asynchronous |
| syncPin | input | 1 | Synchronization-bus trigger, asynchronous |
| sampleValid | input | 1 | Sample word valid this cycle |
| sampleData | input | 64 | Four 16-bit straight-binary samples, channel 0 in the low bits |
| trigOut | output | 1 | One-clock trigger pulse |

## Verification
Two things can land in the same cycle. The first is a crossing on the selected channel while another channel crosses in the same sample word. The bench drives both and expects a pulse only when the selected lane crosses. The second is a qualifying event arriving while the detector is disarmed. The bench drops `armEn` in the very sample that crosses the level and expects no pulse, then re-arms it and expects the next genuine crossing to fire.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam logic [2:0] SRC_SOFT   = 3'd0;
  localparam logic [2:0] SRC_EXT    = 3'd1;
  localparam logic [2:0] SRC_BP     = 3'd2;
  localparam logic [2:0] SRC_STAR   = 3'd3;
  localparam logic [2:0] SRC_SYNC   = 3'd4;
  localparam logic [2:0] SRC_LEVEL  = 3'd5;

  // Strobes from control to datapath; enables already gated by arm.
  typedef struct packed {
    logic swEn;
    logic extEn;
    logic bpEn;
    logic starEn;
    logic syncEn;
    logic levelEn;
    logic fallEdge;
    logic slopeNeg;
  } trig_ctl_t;

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  input  logic [WIDTH-1:0] polFall,
  output logic [WIDTH-1:0] edgeOut
);

  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its history.
  logic [WIDTH-1:0] pipe [STAGES+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= asyncIn;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_comb begin
    edgeOut = (pipe[STAGES-1] & ~pipe[STAGES] & ~polFall) |
              (~pipe[STAGES-1] & pipe[STAGES] & polFall);
  end

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
(
  input  logic      armEn,
  input  logic [2:0] srcSel,
  input  logic      edgeFall,
  input  logic      slopeNeg,
  output trig_ctl_t ctl
);

  always_comb begin
    ctl          = '0;
    ctl.fallEdge = edgeFall;
    ctl.slopeNeg = slopeNeg;
    if (armEn) begin
      unique case (srcSel)
        SRC_SOFT:  ctl.swEn    = 1'b1;
        SRC_EXT:   ctl.extEn   = 1'b1;
        SRC_BP:    ctl.bpEn    = 1'b1;
        SRC_STAR:  ctl.starEn  = 1'b1;
        SRC_SYNC:  ctl.syncEn  = 1'b1;
        SRC_LEVEL: ctl.levelEn = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int SAMPLE_W = 16,
  parameter int LEVEL_W  = 8,
  parameter int BP_LINES = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CHAN_W = $clog2(CHANNELS),
  localparam int BP_W   = $clog2(BP_LINES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  trig_ctl_t                    ctl,
  input  logic [BP_W-1:0]              bpSel,
  input  logic [CHAN_W-1:0]            anaChan,
  input  logic [LEVEL_W-1:0]           levelCode,
  input  logic                         swStrobe,
  input  logic                         extPin,
  input  logic [BP_LINES-1:0]          bpLines,
  input  logic                         starPin,
  input  logic                         syncPin,
  input  logic                         sampleValid,
  input  logic [CHANNELS*SAMPLE_W-1:0] sampleData,
  output logic                         trigOut
);

  localparam int NUM_ASYNC = BP_LINES + 3;
  localparam int IDX_EXT   = BP_LINES;
  localparam int IDX_STAR  = BP_LINES + 1;
  localparam int IDX_SYNC  = BP_LINES + 2;

  // Digital sources: synchronize and pick edges of the chosen polarity.
  logic [NUM_ASYNC-1:0] asyncVec, polVec, edgeVec;

  always_comb begin
    asyncVec = {syncPin, starPin, extPin, bpLines};
    polVec   = {NUM_ASYNC{ctl.fallEdge}};
    polVec[IDX_SYNC] = 1'b0;  // sync bus is rising-edge only
  end

  trig_edge_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (asyncVec),
    .polFall (polVec),
    .edgeOut (edgeVec)
  );

  logic [BP_LINES-1:0] bpEdge;
  assign bpEdge = edgeVec[BP_LINES-1:0];

  // Software strobe: synchronous, rising-edge qualified.
  logic swPrev;
  logic swHit;
  assign swHit = swStrobe & ~swPrev;

  // Level trigger: unpack channels, compare against level in the top byte.
  logic [SAMPLE_W-1:0] chanWord [CHANNELS];
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    assign chanWord[c] = sampleData[c*SAMPLE_W +: SAMPLE_W];
  end

  logic [SAMPLE_W-1:0] threshWord;
  logic                curAbove, prevAbove, primed, levelHit;

  assign threshWord = {levelCode, {(SAMPLE_W-LEVEL_W){1'b0}}};
  assign curAbove   = chanWord[anaChan] >= threshWord;
  assign levelHit   = sampleValid & primed &
                      (ctl.slopeNeg ? (prevAbove & ~curAbove)
                                    : (~prevAbove & curAbove));

  logic hitNow;
  assign hitNow = (ctl.swEn    & swHit)              |
                  (ctl.extEn   & edgeVec[IDX_EXT])   |
                  (ctl.bpEn    & bpEdge[bpSel])      |
                  (ctl.starEn  & edgeVec[IDX_STAR])  |
                  (ctl.syncEn  & edgeVec[IDX_SYNC])  |
                  (ctl.levelEn & levelHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swPrev    <= 1'b0;
      prevAbove <= 1'b0;
      primed    <= 1'b0;
      trigOut   <= 1'b0;
    end else begin
      swPrev  <= swStrobe;
      trigOut <= hitNow;
      if (sampleValid) begin
        prevAbove <= curAbove;
        primed    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/trig_event_detect.sv
module trig_event_detect
  import trig_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int SAMPLE_W = 16,
  parameter int LEVEL_W  = 8,
  parameter int BP_LINES = 8,
  localparam int CHAN_W = $clog2(CHANNELS),
  localparam int BP_W   = $clog2(BP_LINES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         armEn,
  input  logic [2:0]                   srcSel,
  input  logic                         edgeFall,
  input  logic [BP_W-1:0]              bpSel,
  input  logic                         slopeNeg,
  input  logic [CHAN_W-1:0]            anaChan,
  input  logic [LEVEL_W-1:0]           levelCode,
  input  logic                         swStrobe,
  input  logic                         extPin,
  input  logic [BP_LINES-1:0]          bpLines,
  input  logic                         starPin,
  input  logic                         syncPin,
  input  logic                         sampleValid,
  input  logic [CHANNELS*SAMPLE_W-1:0] sampleData,
  output logic                         trigOut
);

  trig_ctl_t ctl;

  trig_ctrl u_ctrl (
    .armEn    (armEn),
    .srcSel   (srcSel),
    .edgeFall (edgeFall),
    .slopeNeg (slopeNeg),
    .ctl      (ctl)
  );

  trig_datapath #(
    .CHANNELS (CHANNELS),
    .SAMPLE_W (SAMPLE_W),
    .LEVEL_W  (LEVEL_W),
    .BP_LINES (BP_LINES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .bpSel       (bpSel),
    .anaChan     (anaChan),
    .levelCode   (levelCode),
    .swStrobe    (swStrobe),
    .extPin      (extPin),
    .bpLines     (bpLines),
    .starPin     (starPin),
    .syncPin     (syncPin),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .trigOut     (trigOut)
  );

endmodule

// File: rtl/trig_event_detect_chk.sv
module trig_event_detect_chk
  import trig_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int SAMPLE_W = 16,
  parameter int LEVEL_W  = 8,
  localparam int CHAN_W = $clog2(CHANNELS)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         armEn,
  input logic [2:0]                   srcSel,
  input logic                         swStrobe,
  input logic                         slopeNeg,
  input logic [CHAN_W-1:0]            anaChan,
  input logic [LEVEL_W-1:0]           levelCode,
  input logic                         sampleValid,
  input logic [CHANNELS*SAMPLE_W-1:0] sampleData,
  input logic                         trigOut
);

  logic [SAMPLE_W-1:0] selWord, thrWord;
  always_comb begin
    selWord = sampleData[anaChan*SAMPLE_W +: SAMPLE_W];
    thrWord = {levelCode, {(SAMPLE_W-LEVEL_W){1'b0}}};
  end

  // R10
  disarm_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(armEn) |-> !trigOut);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  // R11
  no_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(srcSel) > SRC_LEVEL) |-> !trigOut);

  // R2
  soft_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && $past(srcSel) == SRC_SOFT) |-> $past(swStrobe));

  // R8
  up_slope_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && $past(srcSel) == SRC_LEVEL && !$past(slopeNeg))
      |-> ($past(sampleValid) && $past(selWord) >= $past(thrWord)));

  // R9
  down_slope_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && $past(srcSel) == SRC_LEVEL && $past(slopeNeg))
      |-> ($past(sampleValid) && $past(selWord) < $past(thrWord)));

endmodule

bind trig_event_detect trig_event_detect_chk #(
  .CHANNELS (CHANNELS),
  .SAMPLE_W (SAMPLE_W),
  .LEVEL_W  (LEVEL_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .armEn       (armEn),
  .srcSel      (srcSel),
  .swStrobe    (swStrobe),
  .slopeNeg    (slopeNeg),
  .anaChan     (anaChan),
  .levelCode   (levelCode),
  .sampleValid (sampleValid),
  .sampleData  (sampleData),
  .trigOut     (trigOut)
);

// File: tb/trig_event_detect_tb.sv
`timescale 1ns/1ps
module trig_event_detect_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armEn = 1'b0;
  logic [2:0]  srcSel = 3'd7;
  logic        edgeFall = 1'b0;
  logic [2:0]  bpSel = 3'd0;
  logic        slopeNeg = 1'b0;
  logic [1:0]  anaChan = 2'd0;
  logic [7:0]  levelCode = 8'h80;
  logic        swStrobe = 1'b0;
  logic        extPin = 1'b0;
  logic [7:0]  bpLines = 8'h00;
  logic        starPin = 1'b0;
  logic        syncPin = 1'b0;
  logic        sampleValid = 1'b0;
  logic [63:0] sampleData = '0;
  logic        trigOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  trig_event_detect u_dut (
    .clk(clk), .rstN(rstN), .armEn(armEn), .srcSel(srcSel),
    .edgeFall(edgeFall), .bpSel(bpSel), .slopeNeg(slopeNeg),
    .anaChan(anaChan), .levelCode(levelCode), .swStrobe(swStrobe),
    .extPin(extPin), .bpLines(bpLines), .starPin(starPin),
    .syncPin(syncPin), .sampleValid(sampleValid),
    .sampleData(sampleData), .trigOut(trigOut)
  );

  // stim: 0 soft, 1 ext, 2 backplane line, 3 star, 4 sync
  typedef struct packed {
    logic [2:0] src;
    logic       fall;
    logic [2:0] bpIdx;
    logic [2:0] stim;
    logic [2:0] line;
    logic       rise;
    logic [1:0] expCnt;
    logic [2:0] expLat;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 2'd1, 3'd0, 4'd2},   // R2 held strobe
    '{3'd1, 1'b0, 3'd0, 3'd1, 3'd0, 1'b1, 2'd1, 3'd2, 4'd3},   // R3 rising
    '{3'd1, 1'b0, 3'd0, 3'd1, 3'd0, 1'b0, 2'd0, 3'd0, 4'd3},   // R3 wrong edge
    '{3'd1, 1'b1, 3'd0, 3'd1, 3'd0, 1'b0, 2'd1, 3'd2, 4'd3},   // R3 falling
    '{3'd2, 1'b0, 3'd3, 3'd2, 3'd3, 1'b1, 2'd1, 3'd2, 4'd4},   // R4 line 3
    '{3'd2, 1'b0, 3'd3, 3'd2, 3'd5, 1'b1, 2'd0, 3'd0, 4'd4},   // R4 other line
    '{3'd2, 1'b1, 3'd6, 3'd2, 3'd6, 1'b0, 2'd1, 3'd2, 4'd4},   // R4 line 6 fall
    '{3'd3, 1'b0, 3'd0, 3'd3, 3'd0, 1'b1, 2'd1, 3'd2, 4'd5},   // R5 rising
    '{3'd3, 1'b1, 3'd0, 3'd3, 3'd0, 1'b1, 2'd0, 3'd0, 4'd5},   // R5 wrong edge
    '{3'd4, 1'b1, 3'd0, 3'd4, 3'd0, 1'b1, 2'd1, 3'd2, 4'd6},   // R6 rise despite fall
    '{3'd4, 1'b1, 3'd0, 3'd4, 3'd0, 1'b0, 2'd0, 3'd0, 4'd6},   // R6 fall ignored
    '{3'd1, 1'b0, 3'd0, 3'd3, 3'd0, 1'b1, 2'd0, 3'd0, 4'd11},  // R11 star unselected
    '{3'd7, 1'b0, 3'd0, 3'd1, 3'd0, 1'b1, 2'd0, 3'd0, 4'd11}   // R11 no source
  };

  task automatic chk(input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic setPin(input logic [2:0] stim, input logic [2:0] line, input logic val);
    case (stim)
      3'd0: swStrobe = val;
      3'd1: extPin = val;
      3'd2: bpLines[line] = val;
      3'd3: starPin = val;
      default: syncPin = val;
    endcase
  endtask

  // Drive one sample word, observe trigOut just after the accepting edge.
  task automatic sampleStep(input logic [15:0] c0, input logic [15:0] c2,
                            input logic valid, input int exp, input int req);
    @(negedge clk);
    sampleData  = {16'h0000, c2, 16'h0000, c0};
    sampleValid = valid;
    @(negedge clk);
    chk(req, trigOut, exp);
    sampleValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(1, trigOut, 0);  // R1 held in reset
    rstN = 1'b1;
    @(negedge clk);
    chk(1, trigOut, 0);  // R1 first clock after release
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    doReset();

    // Digital and software sources from the vector table
    for (int v = 0; v < NV; v++) begin
      vec_t vec;
      int cnt;
      int first;
      vec = VECS[v];
      @(negedge clk);
      armEn = 1'b0;
      srcSel = vec.src; edgeFall = vec.fall; bpSel = vec.bpIdx;
      swStrobe = 1'b0; extPin = 1'b0; bpLines = '0; starPin = 1'b0; syncPin = 1'b0;
      setPin(vec.stim, vec.line, ~vec.rise);
      repeat (5) @(negedge clk);
      armEn = 1'b1;
      @(negedge clk);
      setPin(vec.stim, vec.line, vec.rise);
      cnt = 0; first = -1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (trigOut) begin
          if (first < 0) first = k;
          cnt++;
        end
      end
      chk(int'(vec.req), cnt, int'(vec.expCnt));
      if (vec.expCnt != 0) chk(int'(vec.req), first, int'(vec.expLat));
    end

    // Level trigger on channel 2, level 0x80, upward slope
    @(negedge clk);
    armEn = 1'b1; srcSel = 3'd5; anaChan = 2'd2; levelCode = 8'h80; slopeNeg = 1'b0;
    swStrobe = 1'b0; extPin = 1'b0; bpLines = '0; starPin = 1'b0; syncPin = 1'b0;
    sampleData = '0;
    doReset();
    sampleStep(16'h0000, 16'h9000, 1'b1, 0, 1);   // R1 no history yet
    sampleStep(16'h0000, 16'h7FFF, 1'b1, 0, 8);   // R8 downward under upward slope
    sampleStep(16'h0000, 16'h8000, 1'b1, 1, 8);   // R8 reaches level exactly
    sampleStep(16'h0000, 16'h8100, 1'b1, 0, 8);   // R8 stays above
    sampleStep(16'h0000, 16'h7000, 1'b1, 0, 8);   // R8 drops below
    sampleStep(16'h0000, 16'h9000, 1'b0, 0, 7);   // R7 invalid word ignored
    sampleStep(16'h9000, 16'h7000, 1'b1, 0, 7);   // R7 other channel crosses
    sampleStep(16'h0000, 16'h80FF, 1'b1, 1, 7);   // R7 selected lane crosses
    @(negedge clk); slopeNeg = 1'b1;
    sampleStep(16'h0000, 16'h7F00, 1'b1, 1, 9);   // R9 downward crossing
    sampleStep(16'h0000, 16'h7E00, 1'b1, 0, 9);   // R9 stays below
    sampleStep(16'h0000, 16'h8000, 1'b1, 0, 9);   // R9 upward ignored
    @(negedge clk); armEn = 1'b0;
    sampleStep(16'h0000, 16'h7000, 1'b1, 0, 10);  // R10 crossing while disarmed
    @(negedge clk); armEn = 1'b1;
    sampleStep(16'h0000, 16'h9000, 1'b1, 0, 10);  // R10 re-armed, upward
    sampleStep(16'h0000, 16'h7000, 1'b1, 1, 10);  // R10 re-armed crossing fires
    @(negedge clk);
    chk(10, trigOut, 0);                          // R10 single-cycle pulse

    done = 1'b1;
    summary();
    $finish;
  end

endmodule